// File: doc/BRIEF.md
# Dual-Port Memory with Lane-Level Collision Arbiter

This block is a 64-bit wide on-chip memory shared by two masters: a CPU port and a remote bus master port. Both can start an access in the same cycle, to any word and with any mix of byte enables, from a single byte up to a full 64-bit double-word. When the two accesses touch the same bytes of the same word, a fixed rule per combination of read and write decides the outcome. The CPU always wins. The remote side is stalled, forwarded to, or has its data dropped, depending on the case.

The CPU port never waits. It returns read data one cycle after the request. The remote port holds its request until `rb_ready`. Internally it moves data in 32-bit halves, lower half first, so a request that enables bytes in both halves takes two transfers. Collisions are resolved byte lane by byte lane. Lanes that do not overlap proceed as if the other port were idle.

Top module: `dpmem_arbiter`

## Requirements
- R1: The memory holds DEPTH words of 64 bits. Byte enable bit i selects data bits [8i+7:8i] on either port, and a write changes exactly the enabled bytes of the addressed word.
- R2: `cpu_ready` is always high. A CPU read accepted at a clock edge shows `cpu_rvalid` high and its data on `cpu_rdata` during the following cycle. Bytes whose enable was low are unspecified.
- R3: A remote request is served as 32-bit transfers: lanes 0–3 first, then lanes 4–7. A half with no enabled lane is skipped. `rb_ready` is high in the cycle the last transfer completes. For a read, `rb_rvalid` and `rb_rdata` follow in the next cycle, and bytes that were not enabled are unspecified.
- R4: When both ports read overlapping lanes of one word, both receive the stored content and the remote transfer is not delayed.
- R5: When a CPU write overlaps lanes of the remote read transfer in progress, that transfer stalls for one cycle. It then returns the value the CPU wrote.
- R6: When a remote write overlaps lanes of a CPU read, the remote data is stored. The CPU read data on those lanes carries the remote write data.
- R7: When both ports write overlapping lanes, the CPU data is stored on those lanes and the remote data for them is dropped. Remote lanes that do not overlap are still written, and the remote transfer completes without stall.
- R8: Collisions are judged per byte lane. Accesses to different words, or to disjoint lanes of one word, cause neither a stall nor forwarding.
- R9: After reset, `cpu_rvalid`, `rb_rvalid` and `rb_ready` are low, and the remote sequencer starts on the lower half. Reset is applied asynchronously and released on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_ready | output | 1 | CPU request accepted (always high) |
| cpu_we | input | 1 | CPU write when high, read when low |
| cpu_addr | input | AW | CPU word address |
| cpu_be | input | 8 | CPU byte enables |
| cpu_wdata | input | 64 | CPU write data |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | 64 | CPU read data |
| rb_valid | input | 1 | Remote request present, held until ready |
| rb_ready | output | 1 | Remote request completed |
| rb_we | input | 1 | Remote write when high, read when low |
| rb_addr | input | AW | Remote word address |
| rb_be | input | 8 | Remote byte enables |
| rb_wdata | input | 64 | Remote write data |
| rb_rvalid | output | 1 | Remote read data valid |
| rb_rdata | output | 64 | Remote read data |

## Verification
The assertions assume that a remote master keeps `rb_valid`, address, enables and data stable until `rb_ready`. They also assume that both inputs are driven low during reset. The bench follows these rules: each remote request stays constant until its completion cycle, and the CPU request is present only in the first cycle of each case. A sweep covers every pairing of CPU idle, read and write with remote read and write, same and different words, and sets of byte enables chosen to give lower-half, upper-half, split and partial overlaps. Expected data, completion cycle and final memory contents are computed from a bench-side copy of the memory.

// File: rtl/dpmem_pkg.sv
package dpmem_pkg;
  localparam int unsigned WORD_BITS  = 64;
  localparam int unsigned LANES      = WORD_BITS / 8;
  localparam int unsigned HALF_LANES = LANES / 2;

  typedef logic [LANES-1:0]     lane_mask_t;
  typedef logic [WORD_BITS-1:0] word_t;

  // Keep only the enables that fall in the selected half.
  function automatic lane_mask_t half_mask(input lane_mask_t be, input logic upper);
    lane_mask_t m;
    for (int unsigned i = 0; i < LANES; i++)
      m[i] = be[i] & ((i >= HALF_LANES) == upper);
    return m;
  endfunction
endpackage

// File: rtl/dpmem_lane_cmp.sv
module dpmem_lane_cmp
  import dpmem_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_valid,
  input  logic       cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  lane_mask_t cpu_be,
  input  logic       rb_valid,
  input  logic       rb_we,
  input  logic [AW-1:0] rb_addr,
  input  lane_mask_t rb_lanes,
  output logic       rb_stall,
  output lane_mask_t rb_wmask,
  output lane_mask_t fwd_mask
);
  logic       same_word;
  lane_mask_t overlap;
  lane_mask_t stall_lane;

  assign same_word = cpu_valid & rb_valid & (cpu_addr == rb_addr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      overlap[i]    = same_word & cpu_be[i] & rb_lanes[i];
      stall_lane[i] = overlap[i] & cpu_we & ~rb_we;
      fwd_mask[i]   = overlap[i] & ~cpu_we & rb_we;
      rb_wmask[i]   = rb_valid & rb_we & rb_lanes[i] & ~(overlap[i] & cpu_we);
    end
  end

  assign rb_stall = |stall_lane;

  p_rr_nostall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_we && !(cpu_valid && cpu_we)) |-> !rb_stall);
  p_wr_nostall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && rb_we) |-> !rb_stall);
  p_far_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr != rb_addr) |-> (!rb_stall && fwd_mask == '0));
endmodule

// File: rtl/dpmem_rb_seq.sv
module dpmem_rb_seq
  import dpmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rb_valid,
  input  lane_mask_t rb_be,
  input  logic       rb_stall,
  output logic       upper,
  output lane_mask_t lanes,
  output logic       xfer,
  output logic       rb_ready
);
  logic ph_q, ph_d;
  logic lo_any, hi_any, last;

  always_comb begin
    lo_any   = |rb_be[HALF_LANES-1:0];
    hi_any   = |rb_be[LANES-1:HALF_LANES];
    upper    = ph_q | ~lo_any;
    lanes    = half_mask(rb_be, upper);
    last     = upper | ~hi_any;
    xfer     = rb_valid & ~rb_stall;
    rb_ready = xfer & last;
    ph_d     = ph_q;
    if (xfer) ph_d = ~last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph_q <= 1'b0;
    else if (xfer) ph_q <= ph_d;
  end

  p_stall_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rb_stall |-> !rb_ready);
  p_half_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rb_ready |=> !ph_q);
endmodule

// File: rtl/dpmem_store.sv
module dpmem_store
  import dpmem_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  lane_mask_t    cpu_wmask,
  input  word_t         cpu_wdata,
  input  logic [AW-1:0] rb_addr,
  input  lane_mask_t    rb_wmask,
  input  word_t         rb_wdata,
  output word_t         cpu_word,
  output word_t         rb_word
);
  logic [DEPTH*WORD_BITS-1:0] flat;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic cpu_hit, rb_hit;
    assign cpu_hit = (cpu_addr == AW'(w));
    assign rb_hit  = (rb_addr  == AW'(w));
    for (genvar l = 0; l < LANES; l++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
        if (cpu_hit && cpu_wmask[l])
          byte_q <= cpu_wdata[l*8 +: 8];
        else if (rb_hit && rb_wmask[l])
          byte_q <= rb_wdata[l*8 +: 8];
      end
      assign flat[w*WORD_BITS + l*8 +: 8] = byte_q;
    end
  end

  assign cpu_word = flat[cpu_addr*WORD_BITS +: WORD_BITS];
  assign rb_word  = flat[rb_addr*WORD_BITS +: WORD_BITS];

  p_one_writer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !((cpu_addr == rb_addr) && |(cpu_wmask & rb_wmask)));
endmodule

// File: rtl/dpmem_arbiter.sv
module dpmem_arbiter
  import dpmem_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_be,
  input  logic [63:0]   cpu_wdata,
  output logic          cpu_rvalid,
  output logic [63:0]   cpu_rdata,
  input  logic          rb_valid,
  output logic          rb_ready,
  input  logic          rb_we,
  input  logic [AW-1:0] rb_addr,
  input  logic [7:0]    rb_be,
  input  logic [63:0]   rb_wdata,
  output logic          rb_rvalid,
  output logic [63:0]   rb_rdata
);
  logic       rst_meta_q, rst_q;
  logic       upper, xfer, rb_stall;
  lane_mask_t lanes, rb_wmask, fwd_mask, cpu_wmask;
  word_t      cpu_word, rb_word;
  word_t      cpu_rdata_d, rb_rdata_d;
  logic       cpu_rd, rb_cap;

  // Reset: asserted at once, released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_meta_q} <= 2'b00;
    else        {rst_q, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  assign cpu_ready = 1'b1;
  assign cpu_wmask = (cpu_valid && cpu_we) ? cpu_be : '0;
  assign cpu_rd    = cpu_valid & ~cpu_we;
  assign rb_cap    = xfer & ~rb_we;

  dpmem_rb_seq i_seq (
    .clk(clk), .rst_n(rst_q), .rb_valid(rb_valid), .rb_be(rb_be),
    .rb_stall(rb_stall), .upper(upper), .lanes(lanes), .xfer(xfer),
    .rb_ready(rb_ready)
  );

  dpmem_lane_cmp #(.AW(AW)) i_cmp (
    .clk(clk), .rst_n(rst_q), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .rb_valid(rb_valid), .rb_we(rb_we),
    .rb_addr(rb_addr), .rb_lanes(lanes), .rb_stall(rb_stall),
    .rb_wmask(rb_wmask), .fwd_mask(fwd_mask)
  );

  dpmem_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
    .clk(clk), .rst_n(rst_q), .cpu_addr(cpu_addr), .cpu_wmask(cpu_wmask),
    .cpu_wdata(cpu_wdata), .rb_addr(rb_addr), .rb_wmask(rb_wmask),
    .rb_wdata(rb_wdata), .cpu_word(cpu_word), .rb_word(rb_word)
  );

  // Next-state: CPU read merge with forwarding, remote half capture.
  always_comb begin
    rb_rdata_d = rb_rdata;
    for (int unsigned i = 0; i < LANES; i++) begin
      cpu_rdata_d[i*8 +: 8] = fwd_mask[i] ? rb_wdata[i*8 +: 8] : cpu_word[i*8 +: 8];
      if ((i >= HALF_LANES) == upper)
        rb_rdata_d[i*8 +: 8] = rb_word[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cpu_rvalid <= 1'b0;
      rb_rvalid  <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_rd;
      rb_rvalid  <= rb_ready & ~rb_we;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_rd) cpu_rdata <= cpu_rdata_d;
    if (rb_cap) rb_rdata  <= rb_rdata_d;
  end

  p_cpu_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_valid && !cpu_we) |=> cpu_rvalid);
  p_rb_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (rb_ready && !rb_we) |=> rb_rvalid);
  p_ready_valid_r3: assert property (@(posedge clk) disable iff (!rst_q)
    rb_ready |-> rb_valid);

  for (genvar i = 0; i < LANES; i++) begin : g_fwd_chk
    p_forward_r6: assert property (@(posedge clk) disable iff (!rst_q)
      (cpu_rd && rb_valid && rb_we && rb_be[i] && lanes[i] && cpu_be[i]
       && cpu_addr == rb_addr)
      |=> cpu_rdata[i*8 +: 8] == $past(rb_wdata[i*8 +: 8]));
  end
endmodule

// File: tb/test_dpmem_arbiter.sv
`timescale 1ns/1ps
module test_dpmem_arbiter;
  localparam int DEPTH = 4;

  logic        clk, rst_n;
  logic        cpu_valid, cpu_ready, cpu_we, cpu_rvalid;
  logic [1:0]  cpu_addr, rb_addr;
  logic [7:0]  cpu_be, rb_be;
  logic [63:0] cpu_wdata, cpu_rdata, rb_wdata, rb_rdata;
  logic        rb_valid, rb_ready, rb_we, rb_rvalid;

  int total = 0;
  int bad   = 0;
  logic [63:0] model [DEPTH];

  dpmem_arbiter #(.DEPTH(DEPTH)) i_dpmem_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .rb_valid(rb_valid),
    .rb_ready(rb_ready), .rb_we(rb_we), .rb_addr(rb_addr), .rb_be(rb_be),
    .rb_wdata(rb_wdata), .rb_rvalid(rb_rvalid), .rb_rdata(rb_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] bits_of(input logic [7:0] m);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = {8{m[i]}};
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    cpu_valid = 1; cpu_we = 1; cpu_addr = a; cpu_be = be; cpu_wdata = d;
    @(negedge clk);
    cpu_valid = 0;
    model[a] = (model[a] & ~bits_of(be)) | (d & bits_of(be));
  endtask

  task automatic cpu_readback(input logic [1:0] a, input string req);
    @(negedge clk);
    cpu_valid = 1; cpu_we = 0; cpu_addr = a; cpu_be = 8'hFF;
    @(negedge clk);
    cpu_valid = 0;
    check(cpu_rvalid && cpu_rdata == model[a], req, cpu_rdata, model[a]);
  endtask

  task automatic run_case(input int cop, input int rop, input int same,
                          input logic [7:0] cbe, input logic [7:0] rbe, input int idx);
    logic [1:0]  ca, ra;
    logic [63:0] cwd, rwd, old_c, exp_c, exp_r, cm, rm;
    logic [7:0]  first, ov;
    logic        lo, hi, cw, cr, stall, got;
    int          exp_cyc, cyc;
    string       tag;
    ca  = 2'd1;
    ra  = same ? 2'd1 : 2'd2;
    cwd = {16'hC0DE, 16'(idx), 16'hC1C1, 16'(idx * 3)};
    rwd = {16'hBEEF, 16'(idx * 7), 16'h7777, 16'(idx * 5)};
    lo = |rbe[3:0]; hi = |rbe[7:4];
    first = lo ? {4'h0, rbe[3:0]} : {rbe[7:4], 4'h0};
    cw = (cop == 2); cr = (cop == 1);
    ov = (cop != 0 && same != 0) ? (cbe & first) : 8'h00;
    stall = (rop == 0) && cw && (ov != 8'h00);
    exp_cyc = ((lo || hi) ? (int'(lo) + int'(hi)) : 1) + int'(stall);
    old_c = model[ca];
    // Expected CPU read: old content, forwarded lanes from remote write (R6).
    exp_c = old_c;
    if (rop == 1) exp_c = (old_c & ~bits_of(ov)) | (rwd & bits_of(ov));
    // Model update: CPU first, then remote lanes not claimed by CPU (R7).
    if (cw) model[ca] = (model[ca] & ~bits_of(cbe)) | (cwd & bits_of(cbe));
    exp_r = model[ra];
    if (rop == 1) begin
      logic [7:0] keep;
      keep = rbe & ~(cw ? ov : 8'h00);
      model[ra] = (model[ra] & ~bits_of(keep)) | (rwd & bits_of(keep));
    end
    if (same == 0) tag = "R8";
    else if (stall) tag = "R5";
    else if (cr && rop == 0) tag = "R4";
    else if (cr && rop == 1) tag = "R6";
    else if (cw && rop == 1) tag = "R7";
    else tag = "R3";

    @(negedge clk);
    cpu_valid = (cop != 0); cpu_we = cw; cpu_addr = ca; cpu_be = cbe; cpu_wdata = cwd;
    rb_valid = 1; rb_we = (rop == 1); rb_addr = ra; rb_be = rbe; rb_wdata = rwd;
    cyc = 0;
    forever begin
      #1;
      got = rb_ready;
      @(posedge clk);
      @(negedge clk);
      if (cyc == 0) begin
        cpu_valid = 0;
        if (cr) begin
          cm = bits_of(cbe);
          check(cpu_rvalid && ((cpu_rdata & cm) == (exp_c & cm)), tag,
                cpu_rdata & cm, exp_c & cm);
        end
      end
      if (got) begin
        rb_valid = 0;
        check(cyc + 1 == exp_cyc, stall ? "R5" : "R3", 64'(cyc + 1), 64'(exp_cyc));
        if (rop == 0) begin
          rm = bits_of(rbe);
          check(rb_rvalid && ((rb_rdata & rm) == (exp_r & rm)), tag,
                rb_rdata & rm, exp_r & rm);
        end
        break;
      end
      cyc++;
      if (cyc > 6) begin
        rb_valid = 0;
        check(1'b0, "R3", 64'(cyc), 64'(exp_cyc));
        break;
      end
    end
    cpu_readback(ca, (cw && rop == 1 && same != 0) ? "R7" : "R1");
    if (ra != ca) cpu_readback(ra, "R1");
  endtask

  initial begin
    logic [7:0] cset [5];
    logic [7:0] rset [5];
    int idx;
    cset = '{8'h01, 8'h0F, 8'hF0, 8'hFF, 8'h3C};
    rset = '{8'h0F, 8'hF0, 8'hFF, 8'h18, 8'h03};
    rst_n = 0; cpu_valid = 0; cpu_we = 0; cpu_addr = 0; cpu_be = 0; cpu_wdata = 0;
    rb_valid = 0; rb_we = 0; rb_addr = 0; rb_be = 0; rb_wdata = 0;
    repeat (3) @(negedge clk);
    check(!cpu_rvalid && !rb_rvalid && !rb_ready, "R9",
          {61'd0, cpu_rvalid, rb_rvalid, rb_ready}, 64'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!cpu_rvalid && !rb_rvalid && !rb_ready, "R9",
          {61'd0, cpu_rvalid, rb_rvalid, rb_ready}, 64'd0);
    check(cpu_ready, "R2", {63'd0, cpu_ready}, 64'd1);
    for (int w = 0; w < DEPTH; w++) begin
      model[w] = '0;
      cpu_write(2'(w), 8'hFF, 64'h0123_4567_89AB_CDEF ^ {8{8'(w * 17)}});
    end
    for (int w = 0; w < DEPTH; w++) cpu_readback(2'(w), "R1");
    idx = 0;
    for (int cop = 0; cop < 3; cop++)
      for (int rop = 0; rop < 2; rop++)
        for (int same = 0; same < 2; same++)
          for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++) begin
              run_case(cop, rop, same, cset[a], rset[b], idx);
              idx++;
            end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule